// File: doc/BRIEF.md
# Operand Bypass and Load Interlock Control

This block decides, for a five-stage in-order integer pipeline, where each operand should come from. It compares the source register numbers of the instruction in the execute stage with the destinations of the two older instructions still in flight. For each of the two ALU inputs it returns a select code that picks the register-file value, the result held in the memory/writeback register, or the result held in the execute/memory register. A third select chooses the write data of a store that has reached the memory stage. In that case the data can come from the result of the instruction one step ahead of the store, for example a load.

The block also finds the one case that bypassing cannot cover. This is a load in execute whose destination is read by the instruction in decode. When that happens it raises a hold for the PC and the fetch/decode register, and a bubble request that loads zeroed control into the decode/execute register. This lasts exactly one cycle. After it, the loaded value sits in memory/writeback and the normal bypass supplies it. A store in decode that uses the loaded register only as its data source is not stalled. Its data is forwarded later in the memory stage.

The unit is purely combinational. The register file, the ALU, the memories and branch handling sit outside it.

Top module: `bypass_interlock_unit`

## Requirements
- R1: When the execute/memory producer has its write enable set, a nonzero destination, and a destination equal to an execute-stage source, that operand's select is 2'b10.
- R2: When only the memory/writeback producer has its write enable set with a nonzero destination equal to an execute-stage source, that operand's select is 2'b01.
- R3: When both producers qualify for the same source, the select is 2'b10, because the younger result wins.
- R4: A destination of register 0, or a producer with its write enable clear, never matches. With no qualifying producer the select is 2'b00, and the code 2'b11 never appears.
- R5: A load in execute (memory-read flag and write enable set, nonzero destination) whose destination equals a decode-stage source raises hold_front and bubble_idex.
- R6: hold_front and bubble_idex are always equal. A matching execute-stage instruction that is not a load raises neither.
- R7: When the decode instruction is a store and the load destination matches only its data source (id_rt), not its base (id_rs), no stall is raised.
- R8: sel_st is 1 exactly when the execute/memory instruction is a store and its data register is a nonzero register equal to the destination of a memory/writeback producer with write enable set.
- R9: A load in execute with destination 0, or with its write enable clear, never raises a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | AW | Decode-stage first source (base for stores) |
| id_rt | input | AW | Decode-stage second source (data for stores) |
| id_is_store | input | 1 | Decode instruction is a store |
| ex_rs | input | AW | Execute-stage first ALU source |
| ex_rt | input | AW | Execute-stage second ALU source |
| ex_rd | input | AW | Execute-stage destination |
| ex_we | input | 1 | Execute-stage register write enable |
| ex_memrd | input | 1 | Execute-stage instruction reads memory (load) |
| exm_rd | input | AW | Execute/memory destination |
| exm_we | input | 1 | Execute/memory register write enable |
| exm_st | input | 1 | Execute/memory instruction is a store |
| exm_st_src | input | AW | Register supplying the store data in memory stage |
| mwb_rd | input | AW | Memory/writeback destination |
| mwb_we | input | 1 | Memory/writeback register write enable |
| sel_a | output | 2 | First ALU operand select (00 file, 01 mem/wb, 10 ex/mem) |
| sel_b | output | 2 | Second ALU operand select, same encoding |
| sel_st | output | 1 | Store write data taken from memory/writeback result |
| hold_front | output | 1 | Hold PC and fetch/decode register |
| bubble_idex | output | 1 | Insert zeroed control into decode/execute |

## Verification
The bench builds the unit with AW = 2, so there are only four register numbers, including register 0. With that width every combination of sources, destinations, write enables and load or store flags can be swept completely. Each sweep covers every equality pattern, register-0 alias and priority conflict. A short ordered sequence then walks a load followed by a dependent instruction through the stall cycle and into the bypass from memory/writeback.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int MAX_AW = 8;

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } opsel_e;

  // True when a producer writes a real register equal to the consumer's source.
  function automatic logic reg_hit(input logic we,
                                   input logic [MAX_AW-1:0] dst,
                                   input logic [MAX_AW-1:0] src);
    return we && (dst != '0) && (dst == src);
  endfunction
endpackage

// File: rtl/op_bypass.sv
module op_bypass
  import hzd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic          exm_we,
  input  logic [AW-1:0] exm_rd,
  input  logic          mwb_we,
  input  logic [AW-1:0] mwb_rd,
  output opsel_e        sel
);
  logic hit_mem;
  logic hit_wb;

  assign hit_mem = reg_hit(exm_we, MAX_AW'(exm_rd), MAX_AW'(src));
  assign hit_wb  = reg_hit(mwb_we, MAX_AW'(mwb_rd), MAX_AW'(src));

  always_comb begin
    if (hit_mem)     sel = SEL_MEM;
    else if (hit_wb) sel = SEL_WB;
    else             sel = SEL_RF;
  end

  always_comb begin
    if (sel == SEL_MEM)
      a_r1_mem_sel_needs_producer: assert (exm_we && exm_rd == src && src != '0);
    if (sel == SEL_WB)
      a_r2_wb_sel_needs_producer: assert (mwb_we && mwb_rd == src && src != '0);
    a_r4_code_legal: assert (sel != 2'b11);
  end
endmodule

// File: rtl/load_use_det.sv
module load_use_det
  import hzd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic          id_is_store,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic          ex_memrd,
  output logic          stall
);
  logic base_dep;
  logic second_dep;

  assign base_dep   = ex_memrd && reg_hit(ex_we, MAX_AW'(ex_rd), MAX_AW'(id_rs));
  // A store's data operand is bypassed in the memory stage instead.
  assign second_dep = ex_memrd && !id_is_store
                      && reg_hit(ex_we, MAX_AW'(ex_rd), MAX_AW'(id_rt));
  assign stall      = base_dep || second_dep;

  always_comb begin
    if (stall)
      a_r5_stall_needs_load: assert (ex_memrd && ex_we && ex_rd != '0);
    if (id_is_store && id_rs != ex_rd)
      a_r7_store_data_no_stall: assert (!stall);
  end
endmodule

// File: rtl/store_data_byp.sv
module store_data_byp
  import hzd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          exm_st,
  input  logic [AW-1:0] exm_st_src,
  input  logic          mwb_we,
  input  logic [AW-1:0] mwb_rd,
  output logic          sel_st
);
  assign sel_st = exm_st && reg_hit(mwb_we, MAX_AW'(mwb_rd), MAX_AW'(exm_st_src));

  always_comb begin
    if (!exm_st)
      a_r8_only_for_store: assert (!sel_st);
  end
endmodule

// File: rtl/bypass_interlock_unit.sv
module bypass_interlock_unit
  import hzd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic          id_is_store,
  input  logic [AW-1:0] ex_rs,
  input  logic [AW-1:0] ex_rt,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic          ex_memrd,
  input  logic [AW-1:0] exm_rd,
  input  logic          exm_we,
  input  logic          exm_st,
  input  logic [AW-1:0] exm_st_src,
  input  logic [AW-1:0] mwb_rd,
  input  logic          mwb_we,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic          sel_st,
  output logic          hold_front,
  output logic          bubble_idex
);
  localparam int NOPS = 2;

  logic [AW-1:0] ex_src [NOPS];
  opsel_e        op_sel [NOPS];
  logic          lu_stall;

  assign ex_src[0] = ex_rs;
  assign ex_src[1] = ex_rt;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    op_bypass #(.AW(AW)) u_byp (
      .src    (ex_src[g]),
      .exm_we (exm_we),
      .exm_rd (exm_rd),
      .mwb_we (mwb_we),
      .mwb_rd (mwb_rd),
      .sel    (op_sel[g])
    );
  end

  assign sel_a = op_sel[0];
  assign sel_b = op_sel[1];

  load_use_det #(.AW(AW)) u_lu (
    .id_rs       (id_rs),
    .id_rt       (id_rt),
    .id_is_store (id_is_store),
    .ex_rd       (ex_rd),
    .ex_we       (ex_we),
    .ex_memrd    (ex_memrd),
    .stall       (lu_stall)
  );

  store_data_byp #(.AW(AW)) u_st (
    .exm_st     (exm_st),
    .exm_st_src (exm_st_src),
    .mwb_we     (mwb_we),
    .mwb_rd     (mwb_rd),
    .sel_st     (sel_st)
  );

  assign hold_front  = lu_stall;
  assign bubble_idex = lu_stall;

  always_comb begin
    a_r6_hold_matches_bubble: assert (hold_front == bubble_idex);
    if (!ex_memrd)
      a_r6_no_stall_without_load: assert (!hold_front);
    if (ex_rd == '0)
      a_r9_zero_dest_no_stall: assert (!bubble_idex);
  end
endmodule

// File: tb/sim_bypass_interlock_unit.sv
module sim_bypass_interlock_unit;
  localparam int AW = 2;
  localparam int NR = 1 << AW;

  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic [AW-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, exm_rd, exm_st_src, mwb_rd;
  logic id_is_store, ex_we, ex_memrd, exm_we, exm_st, mwb_we;
  logic [1:0] sel_a, sel_b;
  logic sel_st, hold_front, bubble_idex;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  bypass_interlock_unit #(.AW(AW)) u0 (.*);

  function automatic logic [1:0] exp_sel(int src, int mrd, int mwe, int wrd, int wwe);
    if (mwe == 1 && mrd != 0 && mrd == src) return 2'b10;
    if (wwe == 1 && wrd != 0 && wrd == src) return 2'b01;
    return 2'b00;
  endfunction

  task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_all();
    {id_rs, id_rt, ex_rs, ex_rt, ex_rd, exm_rd, exm_st_src, mwb_rd} = '0;
    {id_is_store, ex_we, ex_memrd, exm_we, exm_st, mwb_we} = '0;
  endtask

  initial begin
    clear_all();
    repeat (2) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R4 idle sel_a", sel_a, 2'b00);
    chk("R4 idle sel_b", sel_b, 2'b00);
    chk("R6 idle hold", {1'b0, hold_front}, 2'b00);
    chk("R8 idle st", {1'b0, sel_st}, 2'b00);

    // R1 R2 R3 R4: full operand sweep
    for (int s = 0; s < NR; s++)
      for (int m = 0; m < NR; m++)
        for (int mw = 0; mw < 2; mw++)
          for (int w = 0; w < NR; w++)
            for (int ww = 0; ww < 2; ww++) begin
              @(posedge clk);
              ex_rs = AW'(s); ex_rt = AW'((s + 1) % NR);
              exm_rd = AW'(m); exm_we = mw[0]; mwb_rd = AW'(w); mwb_we = ww[0];
              @(negedge clk);
              chk("R1/R2/R3/R4 sel_a", sel_a, exp_sel(s, m, mw, w, ww));
              chk("R1/R2/R3/R4 sel_b", sel_b, exp_sel((s + 1) % NR, m, mw, w, ww));
            end

    // R5 R6 R7 R9: load-use sweep
    clear_all();
    for (int a = 0; a < NR; a++)
      for (int b = 0; b < NR; b++)
        for (int d = 0; d < NR; d++)
          for (int f = 0; f < 8; f++) begin
            logic e;
            @(posedge clk);
            id_rs = AW'(a); id_rt = AW'(b); ex_rd = AW'(d);
            ex_we = f[0]; ex_memrd = f[1]; id_is_store = f[2];
            @(negedge clk);
            e = f[0] && f[1] && d != 0 && (a == d || (!f[2] && b == d));
            chk("R5/R7/R9 hold", {1'b0, hold_front}, {1'b0, e});
            chk("R6 bubble", {1'b0, bubble_idex}, {1'b0, e});
          end

    // R8: store data sweep
    clear_all();
    for (int r = 0; r < NR; r++)
      for (int w = 0; w < NR; w++)
        for (int f = 0; f < 4; f++) begin
          @(posedge clk);
          exm_st_src = AW'(r); mwb_rd = AW'(w); exm_st = f[0]; mwb_we = f[1];
          @(negedge clk);
          chk("R8 sel_st", {1'b0, sel_st},
              {1'b0, (f[0] && f[1] && r != 0 && r == w) ? 1'b1 : 1'b0});
        end

    // R5 then R2: load followed by dependent op, one stall then wb bypass
    clear_all();
    @(posedge clk);
    ex_rd = 2'd3; ex_we = 1; ex_memrd = 1; id_rs = 2'd3; id_rt = 2'd1;
    @(negedge clk);
    chk("R5 seq stall", {1'b0, hold_front}, 2'b01);
    @(posedge clk); // bubble now in ex, load in ex/mem
    ex_rd = 0; ex_we = 0; ex_memrd = 0; exm_rd = 2'd3; exm_we = 1;
    @(negedge clk);
    chk("R5 seq released", {1'b0, hold_front}, 2'b00);
    @(posedge clk); // consumer in ex, load in mem/wb, bubble in ex/mem
    ex_rs = 2'd3; ex_rt = 2'd1; exm_rd = 0; exm_we = 0; mwb_rd = 2'd3; mwb_we = 1;
    @(negedge clk);
    chk("R2 seq wb bypass", sel_a, 2'b01);
    chk("R4 seq other operand", sel_b, 2'b00);

    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule